// File: doc/BRIEF.md
# MSI capability register file

This block holds the register set of a message-signalled-interrupt capability inside a device's configuration space. Software reaches it through a simple configuration port with a dword address, per-byte write enables and 32-bit write data, and reads it back through a combinational read-data bus. The capability occupies a window of consecutive dwords starting at the parameter `CAP_BASE`. It contains the control word, the low and high message address, the 16-bit message data and the optional per-vector mask and pending registers. The layout and the window length depend on two parameters: 64-bit addressing (`ADDR64`) and per-vector masking (`MASK_EN`).

The message dispatcher reads the stored values from dedicated outputs: enable, granted vector count (log2), 64-bit address, data, mask and pending bits. It sets and clears pending bits through its own strobes, which configuration software cannot write. A legacy level interrupt request passes through the block. It is forced inactive for as long as MSI is enabled.

Top module: `msi_cap_regs`

## Requirements
- R1: The asynchronous reset `rst_ni` low clears the enable bit, the granted-count field, both address dwords, the message data, the mask and the pending bits. The control word then reads with only its fixed capability bits set.
- R2: The control word sits in bits 31:16 of window dword 0, so its bit k is read-data bit 16+k. Bit 0 is enable, bits 3:1 hold the fixed log2 of `NUM_VEC`, bits 6:4 hold the granted count, bit 7 is the fixed 64-bit flag and bit 8 is the fixed masking flag. Only enable and the granted count can be written, through byte enable 2. Bits 15:9 read zero.
- R3: If a write to the granted-count field carries a value above the fixed log2 of `NUM_VEC`, that log2 value is stored instead.
- R4: Window dword 1 is the low message address. Its bits 1:0 always read zero, and the rest is writable.
- R5: With `ADDR64`=1, window dword 2 is the high message address, fully writable, and the dispatcher address is {high, low}. With `ADDR64`=0 the high half reads and exports as zero.
- R6: The message data is window dword 3 with `ADDR64`=1, or dword 2 otherwise. Its bits 15:0 are writable and bits 31:16 read zero.
- R7: With `MASK_EN`=1 the mask is the dword after the data. Only bits 0 to `NUM_VEC`-1 are writable, and the higher bits read zero.
- R8: With `MASK_EN`=1 the pending bits are the dword after the mask. Each cycle a bit is set by `pend_set_i` and cleared by `pend_clr_i`, with clear taking priority. Configuration writes to this dword have no effect.
- R9: A configuration write changes only the bytes whose `cfg_be_i` bit is set.
- R10: The window spans 3, 4, 5 or 6 dwords: 32-bit without masking, 64-bit without masking, 32-bit with masking, and 64-bit with masking. Reads outside it return zero, and writes outside it change nothing.
- R11: `intx_o` follows `intx_req_i` while enable is clear and is 0 while enable is set.
- R12: The dispatcher outputs show the new register values in the cycle after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_addr_i | input | AW | Configuration dword address |
| cfg_we_i | input | 1 | Write strobe |
| cfg_be_i | input | 4 | Byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_addr_i` (combinational) |
| pend_set_i | input | NUM_VEC | Dispatcher sets pending bits |
| pend_clr_i | input | NUM_VEC | Dispatcher clears pending bits |
| intx_req_i | input | 1 | Legacy interrupt request from the function |
| intx_o | output | 1 | Legacy interrupt line, gated by enable |
| msi_en_o | output | 1 | MSI enable |
| msi_mme_o | output | 3 | Granted vector count, log2 |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 16 | Message data |
| vec_mask_o | output | NUM_VEC | Per-vector mask |
| vec_pend_o | output | NUM_VEC | Per-vector pending bits |

## Verification
The assertions check on every cycle that the granted count never exceeds the capable count and that enable stays put without a control write. They also check that a byte-enabled address write lands, that a set pending strobe wins unless it is cleared, that out-of-window reads return zero and that the legacy line is silent while enabled. Only the bench's scenarios can show the read-back encoding of every dword. The same holds for the clamping value, for the read-only fixed bits surviving an all-ones write, and for partial byte writes. The same holds for the ignored writes to the pending dword and outside the window, and for the reset values after a reset in mid-run.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam int CTRL_EN      = 0;
  localparam int CTRL_MMC_LSB = 1;
  localparam int CTRL_MME_LSB = 4;
  localparam int CTRL_A64     = 7;
  localparam int CTRL_PVM     = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_ALO, SEL_AHI, SEL_DATA, SEL_MASK, SEL_PEND
  } cap_sel_e;

  function automatic int cap_dwords(bit a64, bit pvm);
    int nbytes;
    nbytes = pvm ? (a64 ? 24 : 20) : (a64 ? 14 : 10);
    return (nbytes + 3) / 4;
  endfunction

  function automatic logic [31:0] be_merge(logic [31:0] old_v, logic [31:0] new_v,
                                           logic [3:0] be);
    logic [31:0] r;
    r = old_v;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/msi_ctrl_reg.sv
module msi_ctrl_reg #(
  parameter int NUM_VEC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wbyte_i,
  output logic       en_o,
  output logic [2:0] mme_o
);
  import msi_cap_pkg::*;

  localparam logic [2:0] MMC = 3'($clog2(NUM_VEC));

  logic       en_q;
  logic [2:0] mme_q;
  logic [2:0] mme_req;

  assign mme_req = wbyte_i[CTRL_MME_LSB +: 3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      mme_q <= 3'd0;
    end else if (we_i) begin
      en_q  <= wbyte_i[CTRL_EN];
      mme_q <= (mme_req > MMC) ? MMC : mme_req;  // silent clamp
    end
  end

  assign en_o  = en_q;
  assign mme_o = mme_q;

  p_mme_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mme_q <= MMC);

  p_en_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_q));

endmodule

// File: rtl/msi_msg_regs.sv
module msi_msg_regs #(
  parameter bit ADDR64 = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_alo_i,
  input  logic        we_ahi_i,
  input  logic        we_data_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] alo_o,
  output logic [31:0] ahi_o,
  output logic [15:0] data_o
);
  import msi_cap_pkg::*;

  logic [31:0] alo_q;
  logic [15:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alo_q  <= '0;
      data_q <= '0;
    end else begin
      if (we_alo_i)  alo_q  <= be_merge(alo_q, wdata_i, be_i) & 32'hFFFF_FFFC;
      if (we_data_i) data_q <= 16'(be_merge({16'h0, data_q}, wdata_i, be_i));
    end
  end

  generate
    if (ADDR64) begin : g_hi
      logic [31:0] ahi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       ahi_q <= '0;
        else if (we_ahi_i) ahi_q <= be_merge(ahi_q, wdata_i, be_i);
      end
      assign ahi_o = ahi_q;
    end else begin : g_no_hi
      assign ahi_o = '0;
    end
  endgenerate

  assign alo_o  = alo_q;
  assign data_o = data_q;

  p_alo_byte_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_alo_i && be_i[1]) |=> alo_q[15:8] == $past(wdata_i[15:8]));

  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_data_i |=> $stable(data_q));

endmodule

// File: rtl/msi_vec_regs.sv
module msi_vec_regs #(
  parameter int NUM_VEC = 8,
  parameter bit MASK_EN = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_mask_i,
  input  logic [3:0]         be_i,
  input  logic [31:0]        wdata_i,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] mask_o,
  output logic [NUM_VEC-1:0] pend_o
);
  import msi_cap_pkg::*;

  generate
    if (MASK_EN) begin : g_mask
      logic [NUM_VEC-1:0] mask_q;
      logic [NUM_VEC-1:0] pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          mask_q <= '0;
          pend_q <= '0;
        end else begin
          if (we_mask_i)
            mask_q <= NUM_VEC'(be_merge(32'(mask_q), wdata_i, be_i));
          pend_q <= (pend_q | set_i) & ~clr_i;
        end
      end
      assign mask_o = mask_q;
      assign pend_o = pend_q;

      p_pend_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        |(set_i & ~clr_i) |=> (pend_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i));

      p_pend_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        |clr_i |=> (pend_q & $past(clr_i)) == '0);
    end else begin : g_no_mask
      assign mask_o = '0;
      assign pend_o = '0;
    end
  endgenerate

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs #(
  parameter int AW       = 6,
  parameter int CAP_BASE = 16,
  parameter int NUM_VEC  = 8,
  parameter bit ADDR64   = 1'b1,
  parameter bit MASK_EN  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      cfg_addr_i,
  input  logic               cfg_we_i,
  input  logic [3:0]         cfg_be_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  input  logic [NUM_VEC-1:0] pend_set_i,
  input  logic [NUM_VEC-1:0] pend_clr_i,
  input  logic               intx_req_i,
  output logic               intx_o,
  output logic               msi_en_o,
  output logic [2:0]         msi_mme_o,
  output logic [63:0]        msg_addr_o,
  output logic [15:0]        msg_data_o,
  output logic [NUM_VEC-1:0] vec_mask_o,
  output logic [NUM_VEC-1:0] vec_pend_o
);
  import msi_cap_pkg::*;

  localparam int          CAP_DW   = cap_dwords(ADDR64, MASK_EN);
  localparam logic [AW-1:0] BASE   = AW'(CAP_BASE);
  localparam logic [AW-1:0] OFF_DATA = ADDR64 ? AW'(3) : AW'(2);
  localparam logic [AW-1:0] OFF_MASK = OFF_DATA + AW'(1);
  localparam logic [AW-1:0] OFF_PEND = OFF_DATA + AW'(2);
  localparam logic [2:0]  MMC      = 3'($clog2(NUM_VEC));

  logic [AW-1:0] off;
  logic          in_win;
  cap_sel_e      sel;

  assign off    = cfg_addr_i - BASE;
  assign in_win = (cfg_addr_i >= BASE) && (off < AW'(CAP_DW));

  always_comb begin
    sel = SEL_NONE;
    if (in_win) begin
      if (off == AW'(0))                 sel = SEL_CTRL;
      else if (off == AW'(1))            sel = SEL_ALO;
      else if (ADDR64 && off == AW'(2))  sel = SEL_AHI;
      else if (off == OFF_DATA)          sel = SEL_DATA;
      else if (MASK_EN && off == OFF_MASK) sel = SEL_MASK;
      else if (MASK_EN && off == OFF_PEND) sel = SEL_PEND;
    end
  end

  logic        en;
  logic [2:0]  mme;
  logic [31:0] alo, ahi;
  logic [15:0] mdata;
  logic [NUM_VEC-1:0] mask, pend;

  msi_ctrl_reg #(.NUM_VEC(NUM_VEC)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && sel == SEL_CTRL && cfg_be_i[2]),
    .wbyte_i (cfg_wdata_i[23:16]),
    .en_o    (en),
    .mme_o   (mme)
  );

  msi_msg_regs #(.ADDR64(ADDR64)) u_msg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_alo_i  (cfg_we_i && sel == SEL_ALO),
    .we_ahi_i  (cfg_we_i && sel == SEL_AHI),
    .we_data_i (cfg_we_i && sel == SEL_DATA),
    .be_i      (cfg_be_i),
    .wdata_i   (cfg_wdata_i),
    .alo_o     (alo),
    .ahi_o     (ahi),
    .data_o    (mdata)
  );

  msi_vec_regs #(.NUM_VEC(NUM_VEC), .MASK_EN(MASK_EN)) u_vec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_mask_i (cfg_we_i && sel == SEL_MASK),
    .be_i      (cfg_be_i),
    .wdata_i   (cfg_wdata_i),
    .set_i     (pend_set_i),
    .clr_i     (pend_clr_i),
    .mask_o    (mask),
    .pend_o    (pend)
  );

  logic [15:0] ctrl_word;
  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN]              = en;
    ctrl_word[CTRL_MMC_LSB +: 3]    = MMC;
    ctrl_word[CTRL_MME_LSB +: 3]    = mme;
    ctrl_word[CTRL_A64]             = ADDR64;
    ctrl_word[CTRL_PVM]             = MASK_EN;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: cfg_rdata_o = {ctrl_word, 16'h0};
      SEL_ALO:  cfg_rdata_o = alo;
      SEL_AHI:  cfg_rdata_o = ahi;
      SEL_DATA: cfg_rdata_o = {16'h0, mdata};
      SEL_MASK: cfg_rdata_o = 32'(mask);
      SEL_PEND: cfg_rdata_o = 32'(pend);
      default:  cfg_rdata_o = '0;
    endcase
  end

  assign intx_o     = intx_req_i & ~en;
  assign msi_en_o   = en;
  assign msi_mme_o  = mme;
  assign msg_addr_o = {ahi, alo};
  assign msg_data_o = mdata;
  assign vec_mask_o = mask;
  assign vec_pend_o = pend;

  p_intx_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_en_o |-> !intx_o);

  p_outside_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i < BASE) |-> cfg_rdata_o == 32'h0);

endmodule

// File: tb/msi_cap_regs_tb.sv
module msi_cap_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int CAP_BASE = 16;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic we = 1'b0;
  logic [3:0] be = '0;
  logic [31:0] wd = '0;
  logic [NV-1:0] pset = '0, pclr = '0;
  logic intx_req = 1'b0;
  logic [31:0] rdata;
  logic intx, en_o;
  logic [2:0] mme_o;
  logic [63:0] maddr;
  logic [15:0] mdata;
  logic [NV-1:0] mask_o, pend_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_cap_regs #(.AW(AW), .CAP_BASE(CAP_BASE), .NUM_VEC(NV), .ADDR64(1'b1), .MASK_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_addr_i(addr), .cfg_we_i(we), .cfg_be_i(be),
    .cfg_wdata_i(wd), .cfg_rdata_o(rdata), .pend_set_i(pset), .pend_clr_i(pclr),
    .intx_req_i(intx_req), .intx_o(intx), .msi_en_o(en_o), .msi_mme_o(mme_o),
    .msg_addr_o(maddr), .msg_data_o(mdata), .vec_mask_o(mask_o), .vec_pend_o(pend_o)
  );

  // behavioural model state
  bit m_en;
  int m_mme;
  logic [31:0] m_alo, m_ahi;
  logic [15:0] m_dat;
  logic [7:0] m_msk, m_pnd;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string tag_ovr = "";

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] b);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (b[i]) r[i*8 +: 8] = n[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] model_read(int off);
    logic [15:0] c;
    c = 16'((1 << 8) | (1 << 7) | (m_mme << 4) | (3 << 1) | int'(m_en));
    case (off)
      0: return {c, 16'h0};
      1: return m_alo;
      2: return m_ahi;
      3: return {16'h0, m_dat};
      4: return {24'h0, m_msk};
      5: return {24'h0, m_pnd};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_en = 0; m_mme = 0; m_alo = 0; m_ahi = 0; m_dat = 0; m_msk = 0; m_pnd = 0;
  endtask

  task automatic model_clock(int off);
    logic [31:0] t;
    if (we) begin
      case (off)
        0: if (be[2]) begin
             m_en = wd[16];
             m_mme = (int'(wd[22:20]) > 3) ? 3 : int'(wd[22:20]);  // R3 clamp to log2(8)
           end
        1: m_alo = merge(m_alo, wd, be) & 32'hFFFF_FFFC;
        2: m_ahi = merge(m_ahi, wd, be);
        3: begin t = merge({16'h0, m_dat}, wd, be); m_dat = t[15:0]; end
        4: begin t = merge({24'h0, m_msk}, wd, be); m_msk = t[7:0]; end
        default: ;
      endcase
    end
    m_pnd = (m_pnd | pset) & ~pclr;
  endtask

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (addr %0d)", tag, got, exp, addr);
    end
  endtask

  function automatic string rd_tag(int off);
    if (tag_ovr != "") return tag_ovr;
    case (off)
      0: return "R2 ctrl";
      1: return "R4 addr_lo";
      2: return "R5 addr_hi";
      3: return "R6 data";
      4: return "R7 mask";
      5: return "R8 pend";
      default: return "R10 outside";
    endcase
  endfunction

  task automatic step(bit rst, logic [AW-1:0] a, bit w, logic [3:0] b, logic [31:0] d,
                      logic [NV-1:0] s, logic [NV-1:0] c, bit ir);
    int off;
    @(negedge clk);
    rst_n = ~rst; addr = a; we = w; be = b; wd = d; pset = s; pclr = c; intx_req = ir;
    #1;
    if (rst) model_reset();
    off = (int'(a) >= CAP_BASE && int'(a) < CAP_BASE + 6) ? int'(a) - CAP_BASE : -1;
    chk(rd_tag(off), 64'(rdata), 64'(model_read(off)));
    chk(tag_ovr != "" ? tag_ovr : "R12 en", 64'(en_o), 64'(m_en));
    chk(tag_ovr != "" ? tag_ovr : "R3 mme", 64'(mme_o), 64'(m_mme));
    chk(tag_ovr != "" ? tag_ovr : "R5 addr", maddr, {m_ahi, m_alo});
    chk(tag_ovr != "" ? tag_ovr : "R6 data out", 64'(mdata), 64'(m_dat));
    chk(tag_ovr != "" ? tag_ovr : "R7 mask out", 64'(mask_o), 64'(m_msk));
    chk(tag_ovr != "" ? tag_ovr : "R8 pend out", 64'(pend_o), 64'(m_pnd));
    chk("R11 intx", 64'(intx), 64'(ir & ~m_en));
    if (!rst) model_clock(off);
  endtask

  localparam logic [AW-1:0] B = AW'(CAP_BASE);

  initial begin
    model_reset();
    tag_ovr = "R1 reset";
    step(1, B, 0, 0, 0, 0, 0, 1);
    step(1, B+1, 1, 4'hF, 32'hFFFF_FFFF, 8'hFF, 0, 0);
    step(1, B+4, 0, 0, 0, 0, 0, 0);
    tag_ovr = "";
    // R2 enable + granted count
    step(0, B, 1, 4'b0100, 32'h0021_0000, 0, 0, 1);
    step(0, B, 0, 0, 0, 0, 0, 1);
    // R3 clamp
    step(0, B, 1, 4'b0100, 32'h0071_0000, 0, 0, 1);
    step(0, B, 0, 0, 0, 0, 0, 0);
    // R2 fixed bits survive all-ones write
    step(0, B, 1, 4'b1100, 32'hFFFF_0000, 0, 0, 0);
    step(0, B, 0, 0, 0, 0, 0, 0);
    // R2 write without byte 2 leaves enable
    step(0, B, 1, 4'b1000, 32'h0000_0000, 0, 0, 0);
    step(0, B, 0, 0, 0, 0, 0, 0);
    // R4 low address lsbs
    step(0, B+1, 1, 4'hF, 32'hDEAD_BEEF, 0, 0, 0);
    step(0, B+1, 0, 0, 0, 0, 0, 0);
    // R9 partial byte write
    tag_ovr = "R9 byte enable";
    step(0, B+1, 1, 4'b0010, 32'h1111_5511, 0, 0, 0);
    step(0, B+1, 0, 0, 0, 0, 0, 0);
    step(0, B+3, 1, 4'b0001, 32'h0000_00A5, 0, 0, 0);
    step(0, B+3, 0, 0, 0, 0, 0, 0);
    tag_ovr = "";
    // R5 high address, R6 data
    step(0, B+2, 1, 4'hF, 32'hCAFE_F00D, 0, 0, 0);
    step(0, B+2, 0, 0, 0, 0, 0, 0);
    step(0, B+3, 1, 4'hF, 32'h1234_ABCD, 0, 0, 0);
    step(0, B+3, 0, 0, 0, 0, 0, 0);
    // R7 mask upper bits not writable
    step(0, B+4, 1, 4'hF, 32'hFFFF_FF5A, 0, 0, 0);
    step(0, B+4, 0, 0, 0, 0, 0, 0);
    // R8 pending set / clear / ignored config write
    step(0, B+5, 0, 0, 0, 8'h81, 0, 0);
    step(0, B+5, 1, 4'hF, 32'h0000_0000, 8'h10, 8'h01, 0);
    step(0, B+5, 0, 0, 0, 8'h02, 8'h02, 0);
    step(0, B+5, 0, 0, 0, 0, 0, 0);
    // R10 outside window
    step(0, B-1, 1, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
    step(0, B+6, 1, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
    step(0, B-1, 0, 0, 0, 0, 0, 0);
    step(0, B+6, 0, 0, 0, 0, 0, 0);
    // R11 enable off releases legacy line
    step(0, B, 1, 4'b0100, 32'h0000_0000, 0, 0, 1);
    step(0, B, 0, 0, 0, 0, 0, 1);
    // mixed random traffic
    for (int i = 0; i < 800; i++) begin
      step(0, AW'(CAP_BASE - 2 + int'($urandom_range(0, 9))), 1'($urandom_range(0, 1)),
           4'($urandom), $urandom, 8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom),
           1'($urandom_range(0, 1)));
    end
    // R1 reset in mid-run
    tag_ovr = "R1 reset";
    step(1, B, 0, 0, 0, 8'hFF, 0, 1);
    step(1, B+2, 0, 0, 0, 0, 0, 0);
    step(1, B+5, 0, 0, 0, 0, 0, 0);
    tag_ovr = "";
    step(0, B, 0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule